// File: doc/BRIEF.md
# Calibration Command Sequencer

This block controls the calibration cycles of a converter front end. A host writes a 3-bit mode code. Two of the codes start a calibration. One measures the zero point of the channel. The other measures its full-scale point. The block counts output-rate periods until the cycle ends. At the end it writes the value on the result bus into the offset or gain coefficient store of the channel that was chosen. Then it returns the mode field to idle by itself. The conversion hardware is not modelled. Its output is the `result` input, and the block samples it at the moments a coefficient is written.

The cycle length depends on the chop setting, which is sampled when the command is accepted. With chop on, a zero-point cycle takes 22 periods and a full-scale cycle takes 44. With chop off, they take 24 and 48. The full-scale cycle runs in two halves. At the halfway period it writes the offset register of the channel, and at the end it writes the gain register. The active-low ready output is held high for the whole calibration. If it was low when the command arrived, it rises on the next modulator tick rather than at once. It goes low when the calibration completes.

Top module: `cal_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mode_q` is 000, `rdy_n` is 1, and `ofs_we` and `gain_we` are 0.
- R2: A write with `mode_wr`=1 of a code other than 100 or 101 while no calibration runs loads that code into `mode_q` at the next edge and leaves `rdy_n` unchanged. Codes 000 (idle), 001 and 010 (conversion) are stored this way.
- R3: A write of code 100 while no calibration runs starts a zero-point calibration, and `mode_q` reads 100. The cycle lasts 22 `period_tick` pulses with chop on and 24 with chop off. Only pulses after the command cycle are counted.
- R4: A write of code 101 while no calibration runs starts a full-scale calibration, and `mode_q` reads 101. The cycle lasts 44 `period_tick` pulses with chop on and 48 with chop off.
- R5: `chop_en` is sampled only in the command cycle. Changes during a calibration do not alter its length.
- R6: If `rdy_n` is 0 when a calibration command is accepted, it rises at the edge of the first `mod_tick` after the command cycle. If it is already 1, it stays 1. It does not rise at any other time.
- R7: At the edge that samples the final period pulse, `mode_q` returns to 000 and `rdy_n` goes to 0.
- R8: A zero-point calibration ends with one single-cycle `ofs_we` pulse and no `gain_we`. `coef_data` equals `result` as sampled at the final pulse.
- R9: A full-scale calibration gives one `ofs_we` pulse at period count len/2 and one `gain_we` pulse at count len. Each carries `result` sampled at that pulse, and the two never coincide.
- R10: Any mode write while a calibration runs is ignored. `mode_q` and the cycle length are unchanged.
- R11: `coef_ch` carries the value of `chan_sel` sampled in the command cycle. Later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code being written |
| chop_en | input | 1 | Chop enable, selects cycle lengths |
| period_tick | input | 1 | One pulse per output-rate period |
| mod_tick | input | 1 | One pulse per modulator cycle |
| chan_sel | input | CH_W | Channel for the coefficient write |
| result | input | RES_W | Conversion result bus |
| rdy_n | output | 1 | Active-low ready flag |
| ofs_we | output | 1 | Offset coefficient write strobe |
| gain_we | output | 1 | Gain coefficient write strobe |
| coef_ch | output | CH_W | Channel of the coefficient write |
| coef_data | output | RES_W | Coefficient value written |
| mode_q | output | 3 | Current mode field |

## Verification
Each of the four combinations of calibration kind and chop setting is run, and the number of period pulses until the mode returns to idle is counted. This tells the four lengths apart, so a swapped or wrong length constant is caught. One full-scale run starts with ready low, so the delayed rise on the modulator tick is exercised. In that same run, chop and channel are toggled and an idle write is made partway through, to show that the values sampled at the command hold. The result bus changes every cycle, so a coefficient sampled one cycle early or late is seen against the reference model.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    MD_IDLE   = 3'b000,
    MD_CONT   = 3'b001,
    MD_SINGLE = 3'b010,
    MD_CAL_ZS = 3'b100,
    MD_CAL_FS = 3'b101
  } mode_e;

  function automatic logic is_cal_code(input logic [2:0] code);
    return (code == MD_CAL_ZS) || (code == MD_CAL_FS);
  endfunction
endpackage

// File: rtl/cal_len_sel.sv
module cal_len_sel #(
  parameter int CNT_W       = 6,
  parameter int ZS_CHOP_LEN = 22,
  parameter int ZS_PLAIN_LEN = 24,
  parameter int FS_CHOP_LEN = 44,
  parameter int FS_PLAIN_LEN = 48
) (
  input  logic             is_fs,
  input  logic             chop,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] half
);
  localparam logic [CNT_W-1:0] L_ZC = CNT_W'(ZS_CHOP_LEN);
  localparam logic [CNT_W-1:0] L_ZP = CNT_W'(ZS_PLAIN_LEN);
  localparam logic [CNT_W-1:0] L_FC = CNT_W'(FS_CHOP_LEN);
  localparam logic [CNT_W-1:0] L_FP = CNT_W'(FS_PLAIN_LEN);

  always_comb begin
    unique case ({is_fs, chop})
      2'b00:   len = L_ZP;
      2'b01:   len = L_ZC;
      2'b10:   len = L_FP;
      default: len = L_FC;
    endcase
    half = len >> 1;
  end
endmodule

// File: rtl/cal_period_cnt.sv
module cal_period_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             busy,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] half,
  output logic             hit_half,
  output logic             hit_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = cnt + 1'b1;
  assign hit_half = busy && tick && (cnt_nxt == half);
  assign hit_end  = busy && tick && (cnt_nxt == len);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (busy && tick) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cal_rdy_ctl.sv
module cal_rdy_ctl (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic mod_tick,
  input  logic done,
  output logic rdy_n
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b1;
      pend  <= 1'b0;
    end else if (done) begin
      rdy_n <= 1'b0;
      pend  <= 1'b0;
    end else if (arm) begin
      pend <= ~rdy_n;
    end else if (pend && mod_tick) begin
      rdy_n <= 1'b1;
      pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int NUM_CH       = 2,
  parameter int RES_W        = 24,
  parameter int ZS_CHOP_LEN  = 22,
  parameter int ZS_PLAIN_LEN = 24,
  parameter int FS_CHOP_LEN  = 44,
  parameter int FS_PLAIN_LEN = 48,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int MAX_LEN = (FS_PLAIN_LEN > FS_CHOP_LEN) ? FS_PLAIN_LEN : FS_CHOP_LEN,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [2:0]       mode_wdata,
  input  logic             chop_en,
  input  logic             period_tick,
  input  logic             mod_tick,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [RES_W-1:0] result,
  output logic             rdy_n,
  output logic             ofs_we,
  output logic             gain_we,
  output logic [CH_W-1:0]  coef_ch,
  output logic [RES_W-1:0] coef_data,
  output logic [2:0]       mode_q
);
  import cal_pkg::*;

  logic             busy, start;
  logic             fs_q, chop_q;
  logic [CH_W-1:0]  ch_q;
  logic [CNT_W-1:0] len, half;
  logic             hit_half, hit_end;
  logic             wr_ofs, wr_gain;

  assign busy    = is_cal_code(mode_q);
  assign start   = mode_wr && !busy && is_cal_code(mode_wdata);
  assign wr_ofs  = (hit_half && fs_q) || (hit_end && !fs_q);
  assign wr_gain = hit_end && fs_q;

  cal_len_sel #(
    .CNT_W(CNT_W), .ZS_CHOP_LEN(ZS_CHOP_LEN), .ZS_PLAIN_LEN(ZS_PLAIN_LEN),
    .FS_CHOP_LEN(FS_CHOP_LEN), .FS_PLAIN_LEN(FS_PLAIN_LEN)
  ) u_len (
    .is_fs(fs_q), .chop(chop_q), .len(len), .half(half)
  );

  cal_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(start), .busy(busy), .tick(period_tick),
    .len(len), .half(half), .hit_half(hit_half), .hit_end(hit_end)
  );

  cal_rdy_ctl u_rdy (
    .clk(clk), .rst(rst), .arm(start), .mod_tick(mod_tick),
    .done(hit_end), .rdy_n(rdy_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_IDLE;
      fs_q   <= 1'b0;
      chop_q <= 1'b0;
      ch_q   <= '0;
    end else if (!busy) begin
      if (mode_wr) mode_q <= mode_wdata;
      if (start) begin
        fs_q   <= (mode_wdata == MD_CAL_FS);
        chop_q <= chop_en;
        ch_q   <= chan_sel;
      end
    end else if (hit_end) begin
      mode_q <= MD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_we    <= 1'b0;
      gain_we   <= 1'b0;
      coef_ch   <= '0;
      coef_data <= '0;
    end else begin
      ofs_we  <= wr_ofs;
      gain_we <= wr_gain;
      if (wr_ofs || wr_gain) begin
        coef_ch   <= ch_q;
        coef_data <= result;
      end
    end
  end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_wr,
  input logic [2:0] mode_wdata,
  input logic       period_tick,
  input logic       rdy_n,
  input logic       ofs_we,
  input logic       gain_we,
  input logic [2:0] mode_q
);
  AST_ZS_START: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[2] && mode_wr && mode_wdata == 3'b100) |=> mode_q == 3'b100); // R3
  AST_FS_START: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[2] && mode_wr && mode_wdata == 3'b101) |=> mode_q == 3'b101); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2] && !period_tick) |=> $stable(mode_q)); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q[2]) && mode_q == 3'b000) |-> !rdy_n); // R7
  AST_RDY_RISE_CAL: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> mode_q[2]); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ofs_we && gain_we)); // R9
  AST_GAIN_FS_ONLY: assert property (@(posedge clk) disable iff (rst)
    gain_we |-> $past(mode_q) == 3'b101); // R9
endmodule

bind cal_seq cal_seq_chk u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
  .period_tick(period_tick), .rdy_n(rdy_n), .ofs_we(ofs_we),
  .gain_we(gain_we), .mode_q(mode_q)
);

// File: tb/cal_seq_tb.sv
module cal_seq_tb_top;
  localparam int RES_W = 24;
  localparam int CH_W  = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_wr = 1'b0;
  logic [2:0]       mode_wdata = 3'b000;
  logic             chop_en = 1'b0;
  logic             period_tick = 1'b0;
  logic             mod_tick = 1'b0;
  logic [CH_W-1:0]  chan_sel = '0;
  logic [RES_W-1:0] result = '0;
  logic             rdy_n, ofs_we, gain_we;
  logic [CH_W-1:0]  coef_ch;
  logic [RES_W-1:0] coef_data;
  logic [2:0]       mode_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 0;
  bit started = 0;

  always #10 clk = ~clk;

  cal_seq dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .chop_en(chop_en), .period_tick(period_tick), .mod_tick(mod_tick),
    .chan_sel(chan_sel), .result(result), .rdy_n(rdy_n), .ofs_we(ofs_we),
    .gain_we(gain_we), .coef_ch(coef_ch), .coef_data(coef_data), .mode_q(mode_q)
  );

  // Reference model
  int m_mode = 0, m_rdy = 1, m_pend = 0, m_cnt = 0, m_len = 0, m_fs = 0, m_ch = 0;
  int m_ofs = 0, m_gain = 0, m_cdata = 0, m_cch = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_mode = 0; m_rdy = 1; m_pend = 0; m_cnt = 0; m_fs = 0; m_ch = 0; m_len = 0;
      m_ofs = 0; m_gain = 0; m_cdata = 0; m_cch = 0;
    end else begin
      m_ofs = 0; m_gain = 0;
      if (!(m_mode == 4 || m_mode == 5)) begin
        if (mode_wr) begin
          m_mode = int'(mode_wdata);
          if (m_mode == 4 || m_mode == 5) begin
            m_fs  = (m_mode == 5);
            m_len = m_fs ? (chop_en ? 44 : 48) : (chop_en ? 22 : 24);
            m_ch  = int'(chan_sel);
            m_cnt = 0;
            if (m_rdy == 0) m_pend = 1;
          end
        end
      end else begin
        if (m_pend && mod_tick) begin m_rdy = 1; m_pend = 0; end
        if (period_tick) begin
          m_cnt++;
          if (m_fs && m_cnt == m_len / 2) begin
            m_ofs = 1; m_cdata = int'(result); m_cch = m_ch;
          end
          if (m_cnt == m_len) begin
            if (m_fs) m_gain = 1; else m_ofs = 1;
            m_cdata = int'(result); m_cch = m_ch;
            m_mode = 0; m_rdy = 0; m_pend = 0;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!started) return;
    check("R7",  "mode_q",    int'(mode_q),    m_mode);
    check("R6",  "rdy_n",     int'(rdy_n),     m_rdy);
    check("R8",  "ofs_we",    int'(ofs_we),    m_ofs);
    check("R9",  "gain_we",   int'(gain_we),   m_gain);
    check("R8",  "coef_data", int'(coef_data), m_cdata);
    check("R11", "coef_ch",   int'(coef_ch),   m_cch);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    mode_wr     = 1'b0;
    period_tick = (cyc % 3 == 2);
    mod_tick    = (cyc % 5 == 4);
    result      = RES_W'(cyc * 40503 + 12345);
    cyc++;
  endtask

  task automatic write_mode(input logic [2:0] code);
    step();
    mode_wr    = 1'b1;
    mode_wdata = code;
  endtask

  task automatic run_cal(input logic [2:0] code, input bit chop, input bit ch,
                         input int exp_len, input bit disturb, input string tag);
    int n = 0;
    int rise_wait = -1;
    int w = 0;
    chop_en  = chop;
    chan_sel = ch;
    write_mode(code);
    while (1) begin
      step();
      w++;
      if (rise_wait < 0 && rdy_n) rise_wait = w;
      if (mode_q == 3'b000) break;
      if (period_tick) n++;
      if (disturb && n == 10) begin
        chop_en    = ~chop;
        chan_sel   = ~ch;
        mode_wr    = 1'b1;
        mode_wdata = 3'b000;
      end
      if (w > 1000) break;
    end
    check(tag, "period pulses in cycle", n, exp_len);
    if (disturb) begin
      check("R10", "length after mid-run write", n, exp_len);
      check("R5",  "length after chop toggle", n, exp_len);
      check("R6",  "rdy_n rose within one modulator cycle", int'(rise_wait >= 1 && rise_wait <= 6), 1);
    end
    chop_en = chop;
    chan_sel = ch;
    step();
    check("R7", "rdy_n low after completion", int'(rdy_n), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "mode_q in reset", int'(mode_q), 0);
    check("R1", "rdy_n in reset", int'(rdy_n), 1);
    check("R1", "strobes in reset", int'(ofs_we | gain_we), 0);
    rst = 1'b0;
    step();
    check("R1", "mode_q after reset", int'(mode_q), 0);
    write_mode(3'b001);
    step();
    check("R2", "conversion code loaded", int'(mode_q), 1);
    check("R2", "rdy_n unaffected", int'(rdy_n), 1);
    write_mode(3'b000);
    step();
    run_cal(3'b100, 1'b1, 1'b0, 22, 1'b0, "R3");
    run_cal(3'b101, 1'b0, 1'b1, 48, 1'b1, "R4");
    run_cal(3'b100, 1'b0, 1'b1, 24, 1'b0, "R3");
    run_cal(3'b101, 1'b1, 1'b0, 44, 1'b0, "R4");
    write_mode(3'b010);
    step();
    check("R2", "conversion code after cal", int'(mode_q), 2);
    check("R2", "rdy_n stays low", int'(rdy_n), 0);
    repeat (4) step();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule